// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Port

This block keeps the colour map used by a pixel pipeline. It has 256 pixel entries, addressed by an 8-bit pixel value, and 4 overlay entries for cursor colours. Every entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. Software reaches the table through a 32-bit register port. It first writes an entry number to the index register. Each later data access then moves one colour component, with the component carried in the top byte of the word. A three-state sequencer steps red, green, blue. After blue it moves to the next entry, so a whole table can be loaded with one index write followed by a stream of data writes.

The sequencer has the states `STEP_RED`, `STEP_GRN` and `STEP_BLU`. It has three transitions:
- ADVANCE: `STEP_RED` to `STEP_GRN`, and `STEP_GRN` to `STEP_BLU`, on any data access.
- WRAP: `STEP_BLU` to `STEP_RED`, on a data access, incrementing the shared index.
- RESTART: any state to `STEP_RED`, on an index-register write, loading the new index.

Reads and writes share this one sequencer. Writes through the overlay offset land in one of the four overlay entries, chosen by the low two index bits.

A separate lookup port serves display logic. It takes an entry number and returns the 24-bit colour on the following cycle.

Top module: `clut_regif`

## Requirements
- R1: After reset every entry is black (0,0,0), except entries 255, 256 and 258, which are white (255,255,255). The index is 0 and the sequencer is at the red step.
- R2: A full-word write at byte offset 0 loads the index from data bits 31:24 and returns the sequencer to red (RESTART).
- R3: A full-word write at byte offset 4 stores data bits 31:24 into the current component of pixel entry [index], then advances the sequencer red, green, blue.
- R4: A full-word write at byte offset 12 stores into overlay entry 256 + (index mod 4), using the same component sequence and the same index increment.
- R5: A data access in the blue step increments the index modulo 256 (255 wraps to 0) and returns the sequencer to red (WRAP).
- R6: A full-word read at any offset returns the current component of pixel entry [index] in bits 31:24, with bits 23:0 zero. It is presented on `bus_rdata` with `bus_rvalid` high in the cycle after the access, and it advances the sequencer.
- R7: Reads and writes consume steps of the one shared sequencer, so interleaved reads and writes each take one component in turn.
- R8: An access whose byte enables are not all four set has no effect: no state changes, no data is stored and no read data is returned.
- R9: A full-word write at any offset other than 0, 4 and 12 changes neither the table, the index nor the sequencer.
- R10: The lookup port takes a 9-bit entry number and, one cycle later, gives {red, green, blue} in bits 23:16, 15:8 and 7:0. Entry numbers of 260 and above give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the index or component |
| bus_rdata | output | 32 | Read data, component in bits 31:24 |
| bus_rvalid | output | 1 | High in the cycle after an accepted read |
| lk_idx | input | 9 | Lookup entry number (0..259) |
| lk_rgb | output | 24 | Colour of the lookup entry, one cycle later |

## Verification
The table is filled by one index write and 768 pixel writes. Each component has its own arithmetic pattern, so a swapped component or a missed step shows as a mismatch, and the final wrap of the index to 0 is observable. A read sweep over every entry then separates the read path and its sequencing from the write path. Short directed runs cover the remaining cases:
- overlay writes at indices whose low bits alias, which distinguish overlay from pixel targets;
- mixed read/write steps on one entry, which show that the sequencer is shared;
- partial-enable and unused-offset writes, each followed by a normal write, which show that these accesses neither stored data nor moved the sequencer.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        STEP_RED = 2'd0,
        STEP_GRN = 2'd1,
        STEP_BLU = 2'd2
    } step_e;

    localparam logic [3:0] OFS_INDEX   = 4'h0;
    localparam logic [3:0] OFS_PIXEL   = 4'h4;
    localparam logic [3:0] OFS_OVERLAY = 4'hC;
    localparam logic [3:0] BE_FULL     = 4'hF;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_idx,
    input  logic [IDX_W-1:0] load_val,
    input  logic             advance,
    output step_e            step,
    output logic [IDX_W-1:0] idx
);

    step_e            step_q;
    step_e            step_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= STEP_RED;
            idx_q  <= '0;
        end else begin
            step_q <= step_d;
            idx_q  <= idx_d;
        end
    end

    // next state: RESTART, ADVANCE, WRAP
    always_comb begin
        step_d = step_q;
        idx_d  = idx_q;
        if (load_idx) begin
            step_d = STEP_RED;
            idx_d  = load_val;
        end else if (advance) begin
            unique case (step_q)
                STEP_RED: step_d = STEP_GRN;
                STEP_GRN: step_d = STEP_BLU;
                STEP_BLU: begin
                    step_d = STEP_RED;
                    idx_d  = idx_q + 1'b1;
                end
                default:  step_d = STEP_RED;
            endcase
        end
    end

    assign step = step_q;
    assign idx  = idx_q;

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int NPIX  = 256,
    parameter int NOVL  = 4,
    parameter int CW    = 8,
    parameter int IDX_W = $clog2(NPIX),
    parameter int ENT_W = $clog2(NPIX + NOVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_ovl,
    input  logic [CW-1:0]    wr_val,
    input  step_e            step,
    input  logic [IDX_W-1:0] idx,
    output logic [CW-1:0]    rd_comp,
    input  logic [ENT_W-1:0] lk_idx,
    output logic [3*CW-1:0]  lk_rgb
);

    localparam int NENT  = NPIX + NOVL;
    localparam int OVL_W = (NOVL > 1) ? $clog2(NOVL) : 1;
    localparam int RGB_W = 3 * CW;

    logic [RGB_W-1:0] ent_all [NENT];
    logic [ENT_W-1:0] wr_sel;
    logic [RGB_W-1:0] cur_ent;
    logic             lk_in_range;
    logic [ENT_W-1:0] lk_safe;
    logic [RGB_W-1:0] lk_q;

    // target entry: pixel entry [idx] or overlay entry NPIX + idx mod NOVL
    always_comb begin
        if (wr_ovl) begin
            wr_sel = ENT_W'(NPIX) + ENT_W'(idx[OVL_W-1:0]);
        end else begin
            wr_sel = ENT_W'(idx);
        end
    end

    // one register set per entry
    for (genvar e = 0; e < NENT; e++) begin : g_ent
        localparam bit IS_WHITE = (e == NPIX - 1) || (e == NPIX) || (e == NPIX + 2);
        logic [RGB_W-1:0] ent_q;
        logic             hit;

        assign hit = wr_en && (wr_sel == ENT_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= IS_WHITE ? {RGB_W{1'b1}} : '0;
            end else if (hit) begin
                unique case (step)
                    STEP_RED: ent_q[RGB_W-1 -: CW] <= wr_val;
                    STEP_GRN: ent_q[2*CW-1 -: CW]  <= wr_val;
                    STEP_BLU: ent_q[CW-1:0]        <= wr_val;
                    default:  ent_q                <= ent_q;
                endcase
            end
        end

        assign ent_all[e] = ent_q;
    end

    // register-port read: current component of pixel entry [idx]
    assign cur_ent = ent_all[ENT_W'(idx)];

    always_comb begin
        unique case (step)
            STEP_RED: rd_comp = cur_ent[RGB_W-1 -: CW];
            STEP_GRN: rd_comp = cur_ent[2*CW-1 -: CW];
            STEP_BLU: rd_comp = cur_ent[CW-1:0];
            default:  rd_comp = '0;
        endcase
    end

    // display lookup, one cycle latency
    assign lk_in_range = (lk_idx < ENT_W'(NENT));
    assign lk_safe     = lk_in_range ? lk_idx : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_in_range ? ent_all[lk_safe] : '0;
        end
    end

    assign lk_rgb = lk_q;

endmodule

// File: rtl/clut_regif.sv
module clut_regif
    import clut_pkg::*;
#(
    parameter int NPIX  = 256,
    parameter int NOVL  = 4,
    parameter int CW    = 8,
    parameter int DW    = 32,
    parameter int ENT_W = $clog2(NPIX + NOVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [3:0]       bus_be,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_rvalid,
    input  logic [ENT_W-1:0] lk_idx,
    output logic [3*CW-1:0]  lk_rgb
);

    localparam int IDX_W = $clog2(NPIX);

    logic             acc_ok;
    logic             do_index;
    logic             do_pix;
    logic             do_ovl;
    logic             do_read;
    logic             advance;
    step_e            step_w;
    logic [IDX_W-1:0] idx_w;
    logic [CW-1:0]    rd_comp;
    logic [DW-1:0]    rdata_q;
    logic             rvalid_q;

    // access decode
    assign acc_ok   = bus_sel && (bus_be == BE_FULL);
    assign do_index = acc_ok && bus_wr && (bus_addr == OFS_INDEX);
    assign do_pix   = acc_ok && bus_wr && (bus_addr == OFS_PIXEL);
    assign do_ovl   = acc_ok && bus_wr && (bus_addr == OFS_OVERLAY);
    assign do_read  = acc_ok && !bus_wr;
    assign advance  = do_pix || do_ovl || do_read;

    clut_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_idx (do_index),
        .load_val (bus_wdata[DW-1 -: IDX_W]),
        .advance  (advance),
        .step     (step_w),
        .idx      (idx_w)
    );

    clut_store #(
        .NPIX  (NPIX),
        .NOVL  (NOVL),
        .CW    (CW),
        .IDX_W (IDX_W),
        .ENT_W (ENT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_pix || do_ovl),
        .wr_ovl  (do_ovl),
        .wr_val  (bus_wdata[DW-1 -: CW]),
        .step    (step_w),
        .idx     (idx_w),
        .rd_comp (rd_comp),
        .lk_idx  (lk_idx),
        .lk_rgb  (lk_rgb)
    );

    // read data output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= do_read;
            if (do_read) begin
                rdata_q <= {rd_comp, {(DW-CW){1'b0}}};
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/clut_regif_chk.sv
module clut_regif_chk #(
    parameter int CW    = 8,
    parameter int DW    = 32,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [3:0]       bus_be,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic             bus_rvalid,
    input logic [1:0]       step,
    input logic [IDX_W-1:0] idx
);

    logic full_acc;
    logic data_acc;
    logic other_wr;

    assign full_acc = bus_sel && (bus_be == 4'hF);
    assign data_acc = full_acc && (!bus_wr || bus_addr == 4'h4 || bus_addr == 4'hC);
    assign other_wr = full_acc && bus_wr && bus_addr != 4'h0 && bus_addr != 4'h4 && bus_addr != 4'hC;

    assert_step_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step != 2'd3);

    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        full_acc && bus_wr && bus_addr == 4'h0
        |=> step == 2'd0 && idx == $past(bus_wdata[DW-1 -: IDX_W]));

    assert_step_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && step != 2'd2
        |=> step == $past(step) + 2'd1 && $stable(idx));

    assert_index_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && step == 2'd2
        |=> step == 2'd0 && idx == $past(idx) + IDX_W'(1));

    assert_partial_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_be != 4'hF |=> $stable(step) && $stable(idx) && !bus_rvalid);

    assert_offset_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> $stable(step) && $stable(idx));

    assert_rvalid_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_acc && !bus_wr |=> bus_rvalid);

    assert_rdata_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> bus_rdata[DW-CW-1:0] == '0);

endmodule

bind clut_regif clut_regif_chk #(
    .CW    (CW),
    .DW    (DW),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .step       (step_w),
    .idx        (idx_w)
);

// File: tb/clut_regif_test.sv
module clut_regif_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [8:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the table and sequencer
    logic [23:0] m_ent [260];
    int          m_idx;
    int          m_step;

    always #2.5 clk = ~clk;

    clut_regif uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .lk_idx     (lk_idx),
        .lk_rgb     (lk_rgb)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int e, input int c);
        return 8'((e * 7 + c * 61 + 5) & 255);
    endfunction

    task automatic m_step_done();
        if (m_step == 2) begin
            m_step = 0;
            m_idx = (m_idx + 1) % 256;
        end else begin
            m_step++;
        end
    endtask

    task automatic m_store(input int ent, input logic [7:0] v);
        case (m_step)
            0: m_ent[ent][23:16] = v;
            1: m_ent[ent][15:8]  = v;
            default: m_ent[ent][7:0] = v;
        endcase
    endtask

    // one bus access; returns at the negedge after the capturing edge
    task automatic bus_acc(input logic wr, input logic [3:0] ofs, input logic [3:0] be,
                           input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = ofs; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic set_index(input int i);
        bus_acc(1'b1, 4'h0, 4'hF, {8'(i), 24'h5A5A5A});
        m_idx = i; m_step = 0;
    endtask

    task automatic wr_pix(input logic [7:0] v);
        bus_acc(1'b1, 4'h4, 4'hF, {v, 24'hFFFFFF});
        m_store(m_idx, v); m_step_done();
    endtask

    task automatic wr_ovl(input logic [7:0] v);
        bus_acc(1'b1, 4'hC, 4'hF, {v, 24'h0});
        m_store(256 + (m_idx % 4), v); m_step_done();
    endtask

    task automatic rd_chk(input string req);
        logic [7:0] e;
        case (m_step)
            0: e = m_ent[m_idx][23:16];
            1: e = m_ent[m_idx][15:8];
            default: e = m_ent[m_idx][7:0];
        endcase
        bus_acc(1'b0, 4'h4, 4'hF, 32'h0);
        check(req, {31'd0, bus_rvalid}, 32'd1);
        check(req, bus_rdata, {e, 24'h0});
        m_step_done();
    endtask

    task automatic lk_chk(input string req, input int ent);
        @(negedge clk);
        lk_idx = 9'(ent);
        @(negedge clk);
        check(req, {8'h0, lk_rgb}, (ent < 260) ? {8'h0, m_ent[ent]} : 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < 260; e++) begin
            m_ent[e] = (e == 255 || e == 256 || e == 258) ? 24'hFFFFFF : 24'h0;
        end
        m_idx = 0; m_step = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents through the lookup port; read data idle
        check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        for (int e = 0; e < 260; e++) lk_chk("R1", e);
        // R10: out-of-range entry numbers
        lk_chk("R10", 260);
        lk_chk("R10", 300);
        lk_chk("R10", 511);
        // R1/R6: after reset index 0 at red
        rd_chk("R1 R6");

        // R2 R3 R5: fill all pixel entries from one index write; ends wrapped to 0
        set_index(0);
        for (int e = 0; e < 256; e++)
            for (int c = 0; c < 3; c++) wr_pix(pat(e, c));
        check("R5 wrap", 32'(m_idx), 32'd0);
        for (int e = 0; e < 256; e++) lk_chk("R3", e);

        // R6 R5: read sweep over all pixel entries
        set_index(0);
        for (int k = 0; k < 768; k++) rd_chk("R6");

        // R4: overlay aliasing, index 6 -> entry 258, index 7 -> 259, index 253 -> 257
        set_index(6);
        wr_ovl(8'h11); wr_ovl(8'h22); wr_ovl(8'h33);
        wr_ovl(8'h44); wr_ovl(8'h55); wr_ovl(8'h66);
        set_index(253);
        wr_ovl(8'h77); wr_ovl(8'h88); wr_ovl(8'h99);
        check("R4 idx", 32'(m_idx), 32'd254);
        lk_chk("R4", 258); lk_chk("R4", 259); lk_chk("R4", 257); lk_chk("R4", 256);
        lk_chk("R4", 6); lk_chk("R4", 7); lk_chk("R4", 253);
        // R5: blue step at index 255 wraps to 0
        set_index(255);
        wr_pix(8'hA1); wr_pix(8'hA2); wr_pix(8'hA3);
        rd_chk("R5");
        lk_chk("R5", 255);

        // R7: interleaved write/read/write on one entry, then read next entry
        set_index(10);
        wr_pix(8'hC1);
        rd_chk("R7");
        wr_pix(8'hC3);
        rd_chk("R7");
        lk_chk("R7", 10);

        // R8: partial byte enables ignored
        set_index(20);
        bus_acc(1'b1, 4'h4, 4'h7, 32'hEE000000);
        bus_acc(1'b1, 4'h0, 4'hE, 32'h05000000);
        bus_acc(1'b0, 4'h4, 4'h3, 32'h0);
        check("R8 rvalid", {31'd0, bus_rvalid}, 32'd0);
        lk_chk("R8", 20);
        wr_pix(8'h3C);
        lk_chk("R8", 20);

        // R9: unused offsets ignored
        set_index(30);
        bus_acc(1'b1, 4'h8, 4'hF, 32'hDD000000);
        bus_acc(1'b1, 4'h2, 4'hF, 32'hDD000000);
        lk_chk("R9", 30);
        wr_pix(8'h4B);
        lk_chk("R9", 30);
        rd_chk("R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule